// File: doc/BRIEF.md
# Packed-Pixel SPI Frame Loader

This block takes one display frame from a host over a receive-only SPI slave link and turns it into writes for a pixel buffer. The host drives serial data, a serial clock and an active-low select. Nothing is sent back to the host. Each byte on the wire carries two 3-bit grayscale pixels. Groups of three bytes describe six neighbouring pixels. A frame is 1001 such groups, which is 3003 bytes.

The loader brings the three host pins into the system clock domain and detects rising serial-clock edges. It collects bits into bytes, most significant bit first, and splits each byte into its two pixels. For each byte it issues one write to an external pixel store. That store is read by a separate refresh engine. Each write carries an address and two pixel values. The address counts in pixels, so the first pixel of byte n lands at pixel 2n.

A one-cycle pulse marks the write of the last byte of a frame. Bytes that arrive after that, while the select stays low, are dropped. Raising the select clears all position state, so the next transfer always starts a fresh frame.

Top module: `pxl_frame_loader`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `wr_en` and `frame_done` are 0.
- R2: Bits are taken from `spi_mosi` on rising edges of `spi_sck` while `spi_cs_n` is low, most significant bit first (SPI mode 0). The write for a byte is visible on `wr_en` at the fourth rising `clk` edge after the rising `spi_sck` edge that carries that byte's last bit.
- R3: For a received byte b, `wr_pix_a` equals b[5:3] (the first pixel) and `wr_pix_b` equals b[2:0] (the second pixel). Each is a 3-bit gray level from 0 to 7.
- R4: Bits 7 and 6 of each byte have no effect on any output.
- R5: The write for the byte at position n of the frame (n counted from 0) has `wr_addr` = 6*(n/3) + 2*(n%3), which equals 2n. `wr_pix_a` belongs at pixel `wr_addr` and `wr_pix_b` at pixel `wr_addr`+1.
- R6: Every complete byte at positions 0 to 3002 produces exactly one single-cycle `wr_en` pulse.
- R7: `frame_done` pulses for exactly one cycle, in the same cycle as the write for byte 3002, and at no other time.
- R8: Bytes after byte 3002 in the same select window produce no `wr_en` and no `frame_done`.
- R9: Raising `spi_cs_n` discards any partly received byte and resets the frame position. The next byte after the select goes low again is written to `wr_addr` 0.
- R10: While `spi_cs_n` is high, toggling `spi_sck` or `spi_mosi` produces no `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Host serial clock, asynchronous to `clk` |
| spi_cs_n | input | 1 | Host select, active low |
| spi_mosi | input | 1 | Host serial data |
| wr_en | output | 1 | One-cycle write strobe to the pixel store |
| wr_addr | output | 13 | Pixel index of `wr_pix_a` |
| wr_pix_a | output | 3 | Gray level for pixel `wr_addr` |
| wr_pix_b | output | 3 | Gray level for pixel `wr_addr`+1 |
| frame_done | output | 1 | One-cycle pulse with the last write of a frame |

## Verification
The path from a serial-clock rising edge to its write has four register stages: two synchroniser stages, the byte assembler, and the write register. The bench therefore stores the cycle number in which it raises the final serial-clock edge of each byte. It compares that number with the cycle number in which its falling-edge monitor first sees `wr_en`, and the difference must be exactly 4. `frame_done` is checked against the same write cycle. Results are only read three system-clock falling edges after the last serial-clock high phase ends, which leaves a margin past the fourth edge. Each byte's write count is taken as a difference across that window, so a missing write and a duplicate write are both caught.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  localparam int PIX_W          = 3;
  localparam int PIX_PER_BYTE   = 2;
  localparam int BYTES_PER_GRP  = 3;
  localparam int PIX_PER_GRP    = PIX_PER_BYTE * BYTES_PER_GRP;
  localparam int PAYLOAD_W      = PIX_W * PIX_PER_BYTE;

  typedef logic [PIX_W-1:0]     pix_t;
  typedef logic [PAYLOAD_W-1:0] payload_t;

  // pixel that lands at the even address of a write
  function automatic pix_t lead_pix(input payload_t p);
    return p[PAYLOAD_W-1 -: PIX_W];
  endfunction

  // pixel that lands at the odd address of a write
  function automatic pix_t trail_pix(input payload_t p);
    return p[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/pfl_sync.sv
module pfl_sync #(
  parameter int               STAGES  = 2,
  parameter int               W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pfl_byte_rx.sv
module pfl_byte_rx
  import pfl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_active,
  input  logic     sck_rise,
  input  logic     mosi_s,
  output logic     byte_valid,
  output payload_t byte_payload
);

  localparam int KEEP = PAYLOAD_W - 1;

  // only the low six bits of a byte survive; earlier bits shift out
  logic [KEEP-1:0] shreg;
  logic [2:0]      bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg        <= '0;
      bit_cnt      <= '0;
      byte_valid   <= 1'b0;
      byte_payload <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (!cs_active) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[KEEP-2:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_valid   <= 1'b1;
          byte_payload <= {shreg, mosi_s};
        end
      end
    end
  end

endmodule

// File: rtl/pfl_addr_gen.sv
module pfl_addr_gen
  import pfl_pkg::*;
#(
  parameter int FRAME_BYTES = 3003,
  localparam int GROUPS     = FRAME_BYTES / BYTES_PER_GRP,
  localparam int PIX_TOTAL  = GROUPS * PIX_PER_GRP,
  localparam int AW         = $clog2(PIX_TOTAL),
  localparam int GW         = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_active,
  input  logic          byte_valid,
  input  payload_t      byte_payload,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output pix_t          wr_pix_a,
  output pix_t          wr_pix_b,
  output logic          frame_done,
  output logic          frame_full
);

  // group*6 + slot*2 built from shifts
  function automatic logic [AW-1:0] pix_addr(input logic [GW-1:0] g,
                                             input logic [1:0]    s);
    logic [AW-1:0] ga;
    logic [AW-1:0] sa;
    ga = AW'(g);
    sa = AW'(s);
    return (ga << 2) + (ga << 1) + (sa << 1);
  endfunction

  logic [GW-1:0] grp;
  logic [1:0]    slot;
  logic          accept;
  logic          last_byte;

  assign accept    = cs_active & byte_valid & ~frame_full;
  assign last_byte = (grp == GW'(GROUPS - 1)) && (slot == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp        <= '0;
      slot       <= '0;
      frame_full <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_pix_a   <= '0;
      wr_pix_b   <= '0;
      frame_done <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      if (!cs_active) begin
        grp        <= '0;
        slot       <= '0;
        frame_full <= 1'b0;
      end else if (accept) begin
        wr_en    <= 1'b1;
        wr_addr  <= pix_addr(grp, slot);
        wr_pix_a <= lead_pix(byte_payload);
        wr_pix_b <= trail_pix(byte_payload);
        if (last_byte) begin
          frame_full <= 1'b1;
          frame_done <= 1'b1;
        end else if (slot == 2'd2) begin
          slot <= '0;
          grp  <= grp + GW'(1);
        end else begin
          slot <= slot + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/pxl_frame_loader.sv
module pxl_frame_loader
  import pfl_pkg::*;
#(
  parameter int FRAME_BYTES  = 3003,
  parameter int SYNC_STAGES  = 2,
  localparam int GROUPS      = FRAME_BYTES / BYTES_PER_GRP,
  localparam int PIX_TOTAL   = GROUPS * PIX_PER_GRP,
  localparam int AW          = $clog2(PIX_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [2:0]    wr_pix_a,
  output logic [2:0]    wr_pix_b,
  output logic          frame_done
);

  logic [2:0] pins_s;
  logic       sck_s, cs_n_s, mosi_s, sck_q;
  logic       sck_rise;
  logic       cs_active;
  logic       byte_valid;
  payload_t   byte_payload;
  logic       frame_full;

  pfl_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  assign {sck_s, cs_n_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise  = sck_s & ~sck_q;
  assign cs_active = ~cs_n_s;

  pfl_byte_rx u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_active    (cs_active),
    .sck_rise     (sck_rise),
    .mosi_s       (mosi_s),
    .byte_valid   (byte_valid),
    .byte_payload (byte_payload)
  );

  pfl_addr_gen #(.FRAME_BYTES(FRAME_BYTES)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_active    (cs_active),
    .byte_valid   (byte_valid),
    .byte_payload (byte_payload),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_pix_a     (wr_pix_a),
    .wr_pix_b     (wr_pix_b),
    .frame_done   (frame_done),
    .frame_full   (frame_full)
  );

endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
  parameter int FRAME_BYTES = 3003,
  localparam int PIX_TOTAL  = (FRAME_BYTES / 3) * 6,
  localparam int AW         = $clog2(PIX_TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_active,
  input logic          byte_valid,
  input logic          frame_full,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          frame_done
);

  AST_DONE_HAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> wr_en); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !wr_en); // R10

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < AW'(PIX_TOTAL - 1)) && !wr_addr[0]); // R5

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_full |=> !wr_en); // R8

  AST_BYTE_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && cs_active && !frame_full) |=> wr_en); // R6

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R6

endmodule

bind pxl_frame_loader pfl_checker #(.FRAME_BYTES(FRAME_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_active  (cs_active),
  .byte_valid (byte_valid),
  .frame_full (frame_full),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .frame_done (frame_done)
);

// File: tb/pxl_frame_loader_test.sv
module pxl_frame_loader_test;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 3003;
  localparam int NVEC       = 8;

  // {byte, expected first pixel, expected second pixel}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'h00, 3'd0, 3'd0},
    {8'h3F, 3'd7, 3'd7},
    {8'h2C, 3'd5, 3'd4},
    {8'h13, 3'd2, 3'd3},
    {8'hC0, 3'd0, 3'd0},
    {8'hFF, 3'd7, 3'd7},
    {8'h8A, 3'd1, 3'd2},
    {8'h61, 3'd4, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        wr_en;
  logic [12:0] wr_addr;
  logic [2:0]  wr_pix_a;
  logic [2:0]  wr_pix_b;
  logic        frame_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int wr_cyc = 0;
  int done_cyc = 0;
  int rise_cyc = 0;
  int pos = 0;
  bit ended = 1'b0;
  logic [12:0] seen_addr;
  logic [2:0]  seen_a, seen_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxl_frame_loader uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_pix_a   (wr_pix_a),
    .wr_pix_b   (wr_pix_b),
    .frame_done (frame_done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_en) begin
      wr_cnt    <= wr_cnt + 1;
      wr_cyc    <= cyc;
      seen_addr <= wr_addr;
      seen_a    <= wr_pix_a;
      seen_b    <= wr_pix_b;
    end
    if (frame_done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_sck  = 1'b0;
      spi_mosi = b[i];
      repeat (2) @(negedge clk);
      spi_sck  = 1'b1;
      rise_cyc = cyc;
      repeat (2) @(negedge clk);
    end
    spi_sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic [2:0] ea,
                           input logic [2:0] eb, input string ptag);
    int w0, d0;
    w0 = wr_cnt;
    d0 = done_cnt;
    send_bits(b, 8);
    repeat (3) @(negedge clk);
    if (pos < FRAME) begin
      chk("R6", "write count", wr_cnt - w0, 1);
      chk("R2", "write latency", wr_cyc - rise_cyc, 4);
      chk("R5", "address", int'(seen_addr), 2 * pos);
      chk(ptag, "first pixel", int'(seen_a), int'(ea));
      chk(ptag, "second pixel", int'(seen_b), int'(eb));
      chk("R7", "done count", done_cnt - d0, (pos == FRAME - 1) ? 1 : 0);
      if (pos == FRAME - 1) chk("R7", "done cycle", done_cyc, wr_cyc);
    end else begin
      chk("R8", "extra write count", wr_cnt - w0, 0);
      chk("R8", "extra done count", done_cnt - d0, 0);
    end
    pos++;
  endtask

  task automatic reopen();
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    pos = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int w0;
    logic [7:0] b;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "wr_en in reset", int'(wr_en), 0);
    chk("R1", "frame_done in reset", int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "wr_en after reset", int'(wr_en), 0);
    chk("R1", "frame_done after reset", int'(frame_done), 0);

    // R10: clocking with select high writes nothing
    w0 = wr_cnt;
    send_bits(8'hA5, 8);
    send_bits(8'h3C, 8);
    repeat (4) @(negedge clk);
    chk("R10", "writes while deselected", wr_cnt - w0, 0);

    // table of bytes: R3 unpacking, R4 ignored top bits
    reopen();
    for (int k = 0; k < NVEC; k++)
      send_byte(VEC[k][13:6], VEC[k][5:3], VEC[k][2:0],
                (VEC[k][13:12] != 2'b00) ? "R4" : "R3");

    // R9: a partial byte then deselect; the next byte goes to address 0
    send_bits(8'hFF, 5);
    reopen();
    send_byte(8'h2C, 3'd5, 3'd4, "R9");

    // rest of a full frame, then bytes past its end
    while (pos < FRAME + 3) begin
      b = 8'(pos * 37 + (pos >> 3));
      send_byte(b, b[5:3], b[2:0], "R3");
    end

    // R9: after a full frame, a new window starts over at address 0
    reopen();
    send_byte(8'h1A, 3'd3, 3'd2, "R9");
    chk("R9", "restart address", int'(seen_addr), 0);

    finish_run();
  end

endmodule